// File: doc/BRIEF.md
# Sector Protection Register with Serial Access

This block is the device-side logic of a serial flash that holds an eight-byte sector protection register, one byte per sector, and exposes it over a mode 0/3 SPI slave port. A host writes the register with a frame that starts with a fixed four-byte unlock sequence, followed by exactly eight data bytes. The new value is taken only when chip select returns high, and only when the frame was well formed. A host reads the register with a one-byte read opcode and three dummy bytes. After the dummy bytes the block shifts the sector bytes out in sector order.

All logic runs on one system clock. The SPI pins are brought in through synchronizer stages and their edges are detected in that clock domain. The serial clock half period must therefore be at least SYNC_STAGES+4 system clocks. The serial output is paired with an output enable for the pad buffer. The enable is high only during the data phase of a read, and the pad is in high impedance at all other times. A saturating counter records how many program operations have taken effect. A flag goes high once the counter reaches the endurance limit. Programming still works after that point.

Top module: `sect_prot_spi`

## Requirements
- R1: After reset the output enable is low, the program counter and the limit flag are zero, and all eight sector bytes read back as 00h.
- R2: A frame consisting of the bytes 3Dh, 2Ah, 7Fh and FCh, then exactly eight data bytes, replaces the register when chip select rises. The first data byte goes to sector 0 and the eighth to sector 7.
- R3: A frame of opcode 32h and three dummy bytes causes the sector bytes to be sent in order from sector 0 to sector 7, each MSB first. Each data bit is presented after a falling SCK edge and is valid at the following rising edge, starting with the falling edge that ends the last dummy bit. Input bits are sampled on rising SCK edges.
- R4: Every bit clocked out after the eighth sector byte in a read frame is 1.
- R5: The output enable is high only in the data phase of a read frame. It is low during program frames and returns low after chip select goes high.
- R6: If any of the four unlock bytes does not match, the rest of the frame is ignored. The register and the counter stay unchanged.
- R7: A program frame with seven data bytes, nine data bytes, or a trailing partial byte leaves the register and the counter unchanged.
- R8: Each program operation that takes effect adds one to the counter, which saturates at PROG_LIMIT. The limit flag is high exactly when the counter equals PROG_LIMIT. A program operation at the limit still updates the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Chip select, active low |
| spiSck | input | 1 | Serial clock, idle low or high |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| spiMisoOe | output | 1 | Pad output enable for spiMiso; low means high impedance |
| progCount | output | $clog2(PROG_LIMIT+1) | Program operations taken so far, saturating |
| limitReached | output | 1 | Counter has reached PROG_LIMIT |

## Verification
The commit of a new register value and the saturation of the program counter can fall in the same cycle. Once the counter already holds PROG_LIMIT, a further valid program frame is committed while the counter must hold its value. The bench sets the limit low and then sends more valid frames than the limit allows. It reads the register back after each frame and checks that the last frame's data was taken, while the counter still shows the limit value and the flag stays high. Malformed frames are placed between the valid ones, so that a wrongly committed frame or a wrongly counted frame shows up in both the readback and the counter.

// File: rtl/spp_pkg.sv
`timescale 1ns/1ps
package spp_pkg;
  localparam int BYTE_W  = 8;
  localparam int SECTORS = 8;
  localparam int SEL_W   = $clog2(SECTORS);
  localparam int IDX_W   = $clog2(SECTORS + 2);
  localparam int UNLOCK_LEN = 4;
  localparam int DUMMY_LEN  = 3;

  localparam logic [BYTE_W-1:0] OP_READ = 8'h32;
  localparam logic [BYTE_W-1:0] UNLOCK_SEQ [UNLOCK_LEN] = '{8'h3D, 8'h2A, 8'h7F, 8'hFC};

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_SKIP, ST_DUMMY, ST_PROG, ST_READ
  } spp_state_t;

  typedef struct packed {
    logic              stageWr;
    logic [SEL_W-1:0]  stageIdx;
    logic [BYTE_W-1:0] wrData;
    logic              commit;
    logic              outLoad;
    logic              outShift;
    logic [IDX_W-1:0]  outIdx;
    logic              outEn;
  } spp_strobe_t;
endpackage

// File: rtl/spp_ctrl.sv
`timescale 1ns/1ps
module spp_ctrl
  import spp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiCsN,
  input  logic        spiSck,
  input  logic        spiMosi,
  output spp_strobe_t strobe
);
  logic [SYNC_STAGES-1:0] csPipe, sckPipe, mosiPipe;
  logic csPrev, sckPrev;
  logic csHigh, sckS, mosiS;
  logic csRiseE, csFallE, sckRiseE, sckFallE;

  spp_state_t state;
  logic [2:0]        bitCnt;
  logic [2:0]        outBit;
  logic [1:0]        seqCnt;
  logic [IDX_W-1:0]  dataCnt;
  logic [IDX_W-1:0]  outIdx;
  logic [BYTE_W-1:0] shiftIn;
  logic [BYTE_W-1:0] newByte;

  assign csHigh   = csPipe[SYNC_STAGES-1];
  assign sckS     = sckPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign csRiseE  = csHigh & ~csPrev;
  assign csFallE  = ~csHigh & csPrev;
  assign sckRiseE = ~csHigh & sckS & ~sckPrev;
  assign sckFallE = ~csHigh & ~sckS & sckPrev;
  assign newByte  = {shiftIn[BYTE_W-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sckPipe  <= '0;
      mosiPipe <= '0;
      csPrev   <= 1'b1;
      sckPrev  <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], spiSck};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
      csPrev   <= csHigh;
      sckPrev  <= sckS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      outBit  <= '0;
      seqCnt  <= '0;
      dataCnt <= '0;
      outIdx  <= '0;
      shiftIn <= '0;
      strobe  <= '0;
    end else begin
      strobe.stageWr  <= 1'b0;
      strobe.commit   <= 1'b0;
      strobe.outLoad  <= 1'b0;
      strobe.outShift <= 1'b0;
      if (csRiseE) begin
        if (state == ST_PROG && dataCnt == IDX_W'(SECTORS) && bitCnt == 3'd0)
          strobe.commit <= 1'b1;
        state        <= ST_IDLE;
        strobe.outEn <= 1'b0;
      end else if (csFallE) begin
        state   <= ST_OPC;
        bitCnt  <= '0;
        seqCnt  <= '0;
        dataCnt <= '0;
      end else begin
        if (sckRiseE && state != ST_IDLE && state != ST_SKIP) begin
          shiftIn <= newByte;
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            case (state)
              ST_OPC: begin
                if (seqCnt == 2'd0 && newByte == OP_READ) begin
                  state <= ST_DUMMY;
                end else if (newByte == UNLOCK_SEQ[seqCnt]) begin
                  if (seqCnt == 2'(UNLOCK_LEN - 1)) state <= ST_PROG;
                  else seqCnt <= seqCnt + 2'd1;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_DUMMY: begin
                if (seqCnt == 2'(DUMMY_LEN - 1)) begin
                  state        <= ST_READ;
                  outBit       <= '0;
                  outIdx       <= '0;
                  strobe.outEn <= 1'b1;
                end else begin
                  seqCnt <= seqCnt + 2'd1;
                end
              end
              ST_PROG: begin
                if (dataCnt < IDX_W'(SECTORS)) begin
                  strobe.stageWr  <= 1'b1;
                  strobe.stageIdx <= dataCnt[SEL_W-1:0];
                  strobe.wrData   <= newByte;
                  dataCnt         <= dataCnt + 1'b1;
                end else begin
                  dataCnt <= IDX_W'(SECTORS + 1);
                end
              end
              default: ;
            endcase
          end
        end
        if (sckFallE && state == ST_READ) begin
          if (outBit == 3'd0) begin
            strobe.outLoad <= 1'b1;
            strobe.outIdx  <= outIdx;
          end else begin
            strobe.outShift <= 1'b1;
          end
          outBit <= outBit + 3'd1;
          if (outBit == 3'd7 && outIdx < IDX_W'(SECTORS))
            outIdx <= outIdx + 1'b1;
        end
      end
    end
  end

  AST_COMMIT_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> csHigh); // R2
  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (csHigh && csPrev) |-> !strobe.outEn); // R5
  AST_STAGE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stageWr |-> !csHigh); // R7
endmodule

// File: rtl/spp_dpath.sv
`timescale 1ns/1ps
module spp_dpath
  import spp_pkg::*;
#(
  parameter int PROG_LIMIT = 10000,
  localparam int CNT_W = $clog2(PROG_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  spp_strobe_t      strobe,
  output logic             misoBit,
  output logic             misoOe,
  output logic [CNT_W-1:0] progCount,
  output logic             limitReached
);
  logic [SECTORS-1:0][BYTE_W-1:0] protReg;
  logic [SECTORS-1:0][BYTE_W-1:0] stageReg;
  logic [BYTE_W-1:0]              outShifter;

  assign limitReached = (progCount == CNT_W'(PROG_LIMIT));
  assign misoBit      = outShifter[BYTE_W-1];
  assign misoOe       = strobe.outEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protReg    <= '0;
      stageReg   <= '0;
      outShifter <= '1;
      progCount  <= '0;
    end else begin
      if (strobe.stageWr)
        stageReg[strobe.stageIdx] <= strobe.wrData;
      if (strobe.commit) begin
        protReg <= stageReg;
        if (!limitReached) progCount <= progCount + 1'b1;
      end
      if (strobe.outLoad) begin
        if (strobe.outIdx < IDX_W'(SECTORS))
          outShifter <= protReg[strobe.outIdx[SEL_W-1:0]];
        else
          outShifter <= '1;
      end else if (strobe.outShift) begin
        outShifter <= {outShifter[BYTE_W-2:0], 1'b1};
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    progCount <= CNT_W'(PROG_LIMIT)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (progCount != $past(progCount)) |-> ($past(strobe.commit) && progCount == $past(progCount) + 1'b1)); // R8
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.commit) |-> $stable(protReg)); // R6
endmodule

// File: rtl/sect_prot_spi.sv
`timescale 1ns/1ps
module sect_prot_spi
  import spp_pkg::*;
#(
  parameter int PROG_LIMIT  = 10000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(PROG_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiCsN,
  input  logic             spiSck,
  input  logic             spiMosi,
  output logic             spiMiso,
  output logic             spiMisoOe,
  output logic [CNT_W-1:0] progCount,
  output logic             limitReached
);
  spp_strobe_t ctrlStrobe;

  spp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiCsN  (spiCsN),
    .spiSck  (spiSck),
    .spiMosi (spiMosi),
    .strobe  (ctrlStrobe)
  );

  spp_dpath #(.PROG_LIMIT(PROG_LIMIT)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (ctrlStrobe),
    .misoBit      (spiMiso),
    .misoOe       (spiMisoOe),
    .progCount    (progCount),
    .limitReached (limitReached)
  );
endmodule

// File: tb/sect_prot_spi_test.sv
`timescale 1ns/1ps
module sect_prot_spi_test;
  localparam int LIMIT   = 3;
  localparam int CW      = $clog2(LIMIT + 1);
  localparam int HALF_NS = 32;

  logic clk, rstN, spiCsN, spiSck, spiMosi;
  logic spiMiso, spiMisoOe, limitReached;
  logic [CW-1:0] progCount;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] expReg;
  int expCnt;

  // mode: 0 valid, 1 bad first unlock byte, 2 bad fourth unlock byte,
  // 3 seven data bytes, 4 nine data bytes, 5 trailing partial byte
  localparam logic [67:0] VECS [9] = '{
    {4'd0, 64'hAA55_0F0F_F0F0_1234},
    {4'd1, 64'hFFFF_FFFF_FFFF_FFFF},
    {4'd0, 64'h0102_0304_0506_0708},
    {4'd2, 64'h8080_8080_8080_8080},
    {4'd3, 64'h1111_2222_3333_4444},
    {4'd0, 64'hF00D_CAFE_0000_FFFF},
    {4'd4, 64'h5A5A_5A5A_5A5A_5A5A},
    {4'd5, 64'h7777_6666_5555_4444},
    {4'd0, 64'h8001_4002_2004_1008}
  };

  sect_prot_spi #(.PROG_LIMIT(LIMIT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiMisoOe(spiMisoOe), .progCount(progCount),
    .limitReached(limitReached)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      spiMosi = tx[7-i];
      #(HALF_NS);
      rx[7-i] = spiMiso;
      spiSck = 1'b1;
      #(HALF_NS);
      spiSck = 1'b0;
    end
  endtask

  task automatic frameBegin();
    spiCsN = 1'b0;
    #(HALF_NS);
  endtask

  task automatic frameEnd();
    #(HALF_NS);
    spiCsN = 1'b1;
    #(4 * HALF_NS);
  endtask

  task automatic progFrame(input logic [3:0] mode, input logic [63:0] data);
    logic [7:0] rx;
    int nData;
    nData = (mode == 4'd3) ? 7 : (mode == 4'd4) ? 9 : 8;
    frameBegin();
    sendBits((mode == 4'd1) ? 8'h3E : 8'h3D, 8, rx);
    sendBits(8'h2A, 8, rx);
    sendBits(8'h7F, 8, rx);
    sendBits((mode == 4'd2) ? 8'hFD : 8'hFC, 8, rx);
    for (int i = 0; i < nData; i++)
      sendBits((i < 8) ? data[63-8*i -: 8] : 8'hA5, 8, rx);
    if (mode == 4'd5) sendBits(8'hC0, 3, rx);
    chk("R5 oe low in program frame", {63'd0, spiMisoOe}, 64'd0);
    frameEnd();
  endtask

  task automatic readCheck(input string tag, input logic [63:0] exp);
    logic [7:0] rx;
    logic [63:0] got;
    logic [15:0] tail;
    frameBegin();
    sendBits(8'h32, 8, rx);
    for (int i = 0; i < 3; i++) sendBits(8'h00, 8, rx);
    for (int i = 0; i < 8; i++) begin
      sendBits(8'h00, 8, rx);
      got[63-8*i -: 8] = rx;
      if (i == 0) chk({"R5 oe high in read data ", tag}, {63'd0, spiMisoOe}, 64'd1);
    end
    for (int i = 0; i < 2; i++) begin
      sendBits(8'h00, 8, rx);
      tail[15-8*i -: 8] = rx;
    end
    frameEnd();
    chk({"R3 sector order readback ", tag}, got, exp);
    chk({"R4 ones after eighth byte ", tag}, {48'd0, tail}, 64'h0000_0000_0000_FFFF);
    chk({"R5 oe low after cs rise ", tag}, {63'd0, spiMisoOe}, 64'd0);
  endtask

  initial begin
    rstN = 1'b0; spiCsN = 1'b1; spiSck = 1'b0; spiMosi = 1'b0;
    expReg = '0; expCnt = 0;
    #20 rstN = 1'b1;
    #20;
    // R1 reset state
    chk("R1 oe after reset", {63'd0, spiMisoOe}, 64'd0);
    chk("R1 count after reset", 64'(progCount), 64'd0);
    chk("R1 flag after reset", {63'd0, limitReached}, 64'd0);
    readCheck("R1 reset", 64'd0);

    // table walk: R2 R6 R7 R8
    foreach (VECS[v]) begin
      progFrame(VECS[v][67:64], VECS[v][63:0]);
      if (VECS[v][67:64] == 4'd0) begin
        expReg = VECS[v][63:0];
        if (expCnt < LIMIT) expCnt++;
      end
      readCheck((VECS[v][67:64] == 4'd0) ? "R2 valid" :
                (VECS[v][67:64] <= 4'd2) ? "R6 unlock mismatch" : "R7 bad length", expReg);
      chk("R8 counter value", 64'(progCount), 64'(expCnt));
      chk("R8 limit flag", {63'd0, limitReached}, {63'd0, expCnt == LIMIT});
    end

    // reset in the middle of operation returns to R1 state
    #3 rstN = 1'b0;
    #17 rstN = 1'b1;
    #20;
    chk("R1 count after mid reset", 64'(progCount), 64'd0);
    chk("R1 flag after mid reset", {63'd0, limitReached}, 64'd0);
    readCheck("R1 mid reset", 64'd0);
    progFrame(4'd0, 64'h0123_4567_89AB_CDEF);
    readCheck("R2 after reset", 64'h0123_4567_89AB_CDEF);
    chk("R8 counter restarts", 64'(progCount), 64'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule